// File: doc/BRIEF.md
# CAN FD Error Counter Unit

This block keeps the error bookkeeping of a CAN FD protocol controller. The bit-level logic reports each detected error as a one-cycle pulse on one or more error-type lines. With each pulse it also gives two qualifiers: whether the node was transmitting, and whether the error fell in the fast data phase of a frame with bit-rate switching. A separate pulse reports each frame that completed without error.

The unit keeps two pairs of counters. The main receive and transmit counters see every error, whatever the frame type. The fast receive and transmit counters see only errors in the rate-switched data phase, and both pairs use the same step rules. The unit also holds sticky per-type error flags, with a second flag set for fast-phase errors. From the flags it drives a maskable interrupt. From the main counters only, it derives the fault-confinement state: active, passive or bus-off.

Top module: `canfd_err_track`

## Requirements
- R1: Each cycle with any bit of `err_evt_i` set adds 1 to `rx_cnt_o` when `err_tx_i` is 0, or 8 to `tx_cnt_o` when it is 1, whatever `fast_phase_i` is. The change is visible after the next rising clock edge. Several error bits in the same cycle count as one error.
- R2: A `frame_ok_i` pulse with no error bit in the same cycle subtracts 1 from `rx_cnt_o` (`err_tx_i`=0) or from `tx_cnt_o` (`err_tx_i`=1). A counter at 0 stays at 0.
- R3: The fast counters `fast_rx_cnt_o` and `fast_tx_cnt_o` change only in cycles with `fast_phase_i`=1. In those cycles they follow the R1 and R2 steps. An acknowledge error (bit 3) alone does not advance them.
- R4: When an error and `frame_ok_i` come in the same cycle, only the error step is applied.
- R5: `flags_o` holds sticky flags for both frame types. Bit 0 is stuff, bit 1 form, bit 2 CRC, bit 3 acknowledge, bit 4 dominant-bit error and bit 5 recessive-bit error. Each flag is set by the matching `err_evt_i` bit.
- R6: `fast_flags_o` uses the same bit positions. Its flags are set only in cycles with `fast_phase_i`=1, and bit 3 is always 0.
- R7: A 1 on a bit of `flag_clr_i` or `fast_flag_clr_i` clears that flag. If the same flag is set in the same cycle, the set wins.
- R8: `err_irq_o` is 1 exactly when `err_mask_i` is 1 and at least one bit of `flags_o` or `fast_flags_o` is set.
- R9: `fault_state_o` is 0 (active) while both main counters are below 128. It is 1 (passive) once either counter is 128 or above. The fast counters never affect it.
- R10: `fault_state_o` becomes 2 (bus-off) after a transmit error that would take `tx_cnt_o` past 255. Bus-off holds until reset, and the counters saturate at 255.
- R11: After reset all counters, all flags, `err_irq_o` and `fault_state_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_evt_i | input | 6 | Error-type pulses (bit map as in R5) |
| err_tx_i | input | 1 | 1: node was transmitter |
| fast_phase_i | input | 1 | 1: data phase of a rate-switched frame |
| frame_ok_i | input | 1 | Successful frame pulse |
| flag_clr_i | input | 6 | Write-one clear for `flags_o` |
| fast_flag_clr_i | input | 6 | Write-one clear for `fast_flags_o` |
| err_mask_i | input | 1 | Error interrupt enable |
| rx_cnt_o | output | 8 | Main receive error count |
| tx_cnt_o | output | 8 | Main transmit error count |
| fast_rx_cnt_o | output | 8 | Fast-phase receive error count |
| fast_tx_cnt_o | output | 8 | Fast-phase transmit error count |
| flags_o | output | 6 | Sticky error flags, all phases |
| fast_flags_o | output | 6 | Sticky error flags, fast phase |
| err_irq_o | output | 1 | Masked error interrupt |
| fault_state_o | output | 2 | 0 active, 1 passive, 2 bus-off |

## Verification
The bench uses the default parameters: 8-bit counters, a transmit step of 8, a receive step of 1 and a passive threshold of 128. With these values the 127/128 passive boundary takes 128 receive errors, and the move to bus-off takes 32 transmit errors. That puts both boundaries, the saturation at 255 and the bus-off latch well inside the run. The stimulus table mixes direction, phase, success and acknowledge cases so that every counter path is exercised against hand-computed values.

// File: rtl/canfd_err_pkg.sv
package canfd_err_pkg;
  localparam int NUM_ERR   = 6;
  localparam int ERR_STUFF = 0;
  localparam int ERR_FORM  = 1;
  localparam int ERR_CRC   = 2;
  localparam int ERR_ACK   = 3;
  localparam int ERR_BDOM  = 4;
  localparam int ERR_BREC  = 5;

  localparam logic [NUM_ERR-1:0] FAST_MASK = ~(NUM_ERR'(1) << ERR_ACK);

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUSOFF  = 2'd2
  } fc_state_e;
endpackage

// File: rtl/canfd_err_cnt.sv
module canfd_err_cnt #(
  parameter int W    = 8,
  parameter int STEP = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W:0] MAX = {1'b0, {W{1'b1}}};

  logic [W-1:0] q, d;
  logic [W:0]   sum;

  assign sum = {1'b0, q} + (W+1)'(STEP);

  always_comb begin
    d = q;
    if (inc_i)                   d = (sum > MAX) ? MAX[W-1:0] : sum[W-1:0];
    else if (dec_i && q != '0)   d = q - W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= '0;
    else         q <= d;

  assign cnt_o = q;
endmodule

// File: rtl/canfd_err_flags.sv
module canfd_err_flags #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic f;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)       f <= 1'b0;
      else if (set_i[i]) f <= 1'b1;  // set beats clear
      else if (clr_i[i]) f <= 1'b0;
    assign q_o[i] = f;
  end
endmodule

// File: rtl/canfd_fault_conf.sv
module canfd_fault_conf
  import canfd_err_pkg::*;
#(
  parameter int W          = 8,
  parameter int TX_STEP    = 8,
  parameter int PASSIVE_TH = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] rx_cnt_i,
  input  logic [W-1:0] tx_cnt_i,
  input  logic         tx_inc_i,
  output fc_state_e    state_o
);
  localparam logic [W:0] MAX = {1'b0, {W{1'b1}}};

  logic       busoff_q;
  logic [W:0] tx_next;
  logic       tx_ovf;

  assign tx_next = {1'b0, tx_cnt_i} + (W+1)'(TX_STEP);
  assign tx_ovf  = tx_inc_i && (tx_next > MAX);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     busoff_q <= 1'b0;
    else if (tx_ovf) busoff_q <= 1'b1;

  always_comb begin
    if (busoff_q)
      state_o = FC_BUSOFF;
    else if (32'(rx_cnt_i) >= PASSIVE_TH || 32'(tx_cnt_i) >= PASSIVE_TH)
      state_o = FC_PASSIVE;
    else
      state_o = FC_ACTIVE;
  end
endmodule

// File: rtl/canfd_err_track.sv
module canfd_err_track
  import canfd_err_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int RX_STEP    = 1,
  parameter int TX_STEP    = 8,
  parameter int PASSIVE_TH = 128
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_ERR-1:0] err_evt_i,
  input  logic               err_tx_i,
  input  logic               fast_phase_i,
  input  logic               frame_ok_i,
  input  logic [NUM_ERR-1:0] flag_clr_i,
  input  logic [NUM_ERR-1:0] fast_flag_clr_i,
  input  logic               err_mask_i,
  output logic [CNT_W-1:0]   rx_cnt_o,
  output logic [CNT_W-1:0]   tx_cnt_o,
  output logic [CNT_W-1:0]   fast_rx_cnt_o,
  output logic [CNT_W-1:0]   fast_tx_cnt_o,
  output logic [NUM_ERR-1:0] flags_o,
  output logic [NUM_ERR-1:0] fast_flags_o,
  output logic               err_irq_o,
  output logic [1:0]         fault_state_o
);
  localparam int NCNT = 4;  // 0 rx, 1 tx, 2 fast rx, 3 fast tx

  logic               any_err, fast_err, ok_only;
  logic [NUM_ERR-1:0] fast_set;
  logic [NCNT-1:0]    inc, dec;
  logic [CNT_W-1:0]   cnt [NCNT];
  fc_state_e          fc_state;

  assign any_err  = |err_evt_i;
  assign fast_set = fast_phase_i ? (err_evt_i & FAST_MASK) : '0;
  assign fast_err = |fast_set;
  assign ok_only  = frame_ok_i && !any_err;

  assign inc[0] = any_err  && !err_tx_i;
  assign inc[1] = any_err  &&  err_tx_i;
  assign inc[2] = fast_err && !err_tx_i;
  assign inc[3] = fast_err &&  err_tx_i;
  assign dec[0] = ok_only && !err_tx_i;
  assign dec[1] = ok_only &&  err_tx_i;
  assign dec[2] = ok_only && !err_tx_i && fast_phase_i;
  assign dec[3] = ok_only &&  err_tx_i && fast_phase_i;

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    localparam int STEP = (i % 2 == 1) ? TX_STEP : RX_STEP;
    canfd_err_cnt #(.W(CNT_W), .STEP(STEP)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc[i]),
      .dec_i  (dec[i]),
      .cnt_o  (cnt[i])
    );
  end

  assign rx_cnt_o      = cnt[0];
  assign tx_cnt_o      = cnt[1];
  assign fast_rx_cnt_o = cnt[2];
  assign fast_tx_cnt_o = cnt[3];

  canfd_err_flags #(.N(NUM_ERR)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (err_evt_i),
    .clr_i  (flag_clr_i),
    .q_o    (flags_o)
  );

  canfd_err_flags #(.N(NUM_ERR)) u_fast_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (fast_set),
    .clr_i  (fast_flag_clr_i),
    .q_o    (fast_flags_o)
  );

  assign err_irq_o = err_mask_i && (|flags_o || |fast_flags_o);

  canfd_fault_conf #(
    .W          (CNT_W),
    .TX_STEP    (TX_STEP),
    .PASSIVE_TH (PASSIVE_TH)
  ) u_fc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rx_cnt_i (cnt[0]),
    .tx_cnt_i (cnt[1]),
    .tx_inc_i (inc[1]),
    .state_o  (fc_state)
  );

  assign fault_state_o = fc_state;
endmodule

// File: rtl/canfd_err_track_chk.sv
module canfd_err_track_chk
  import canfd_err_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int PASSIVE_TH = 128
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_ERR-1:0] err_evt_i,
  input logic               err_tx_i,
  input logic               fast_phase_i,
  input logic               frame_ok_i,
  input logic [NUM_ERR-1:0] flag_clr_i,
  input logic [NUM_ERR-1:0] fast_flag_clr_i,
  input logic               err_mask_i,
  input logic [CNT_W-1:0]   rx_cnt_o,
  input logic [CNT_W-1:0]   tx_cnt_o,
  input logic [CNT_W-1:0]   fast_rx_cnt_o,
  input logic [CNT_W-1:0]   fast_tx_cnt_o,
  input logic [NUM_ERR-1:0] flags_o,
  input logic [NUM_ERR-1:0] fast_flags_o,
  input logic               err_irq_o,
  input logic [1:0]         fault_state_o
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  // R1
  rx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|err_evt_i && !err_tx_i && rx_cnt_o != CMAX) |=> rx_cnt_o == $past(rx_cnt_o) + CNT_W'(1));

  // R2
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_evt_i == '0 && frame_ok_i && !err_tx_i && rx_cnt_o == '0) |=> rx_cnt_o == '0);

  // R3
  fast_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fast_phase_i |=> $stable(fast_rx_cnt_o) && $stable(fast_tx_cnt_o));

  // R6
  no_fast_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fast_flags_o[ERR_ACK]);

  // R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_evt_i[ERR_STUFF] && flag_clr_i[ERR_STUFF]) |=> flags_o[ERR_STUFF]);

  // R8
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_mask_i |-> !err_irq_o);

  // R9
  active_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_state_o == 2'd0) |-> (32'(rx_cnt_o) < PASSIVE_TH && 32'(tx_cnt_o) < PASSIVE_TH));

  // R10
  busoff_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_state_o == 2'd2) |=> (fault_state_o == 2'd2));

  // R11
  reset_clean_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (tx_cnt_o == '0 && flags_o == '0 && fast_flags_o == '0 && fast_tx_cnt_o == '0));
endmodule

bind canfd_err_track canfd_err_track_chk #(.CNT_W(CNT_W), .PASSIVE_TH(PASSIVE_TH)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .err_evt_i       (err_evt_i),
  .err_tx_i        (err_tx_i),
  .fast_phase_i    (fast_phase_i),
  .frame_ok_i      (frame_ok_i),
  .flag_clr_i      (flag_clr_i),
  .fast_flag_clr_i (fast_flag_clr_i),
  .err_mask_i      (err_mask_i),
  .rx_cnt_o        (rx_cnt_o),
  .tx_cnt_o        (tx_cnt_o),
  .fast_rx_cnt_o   (fast_rx_cnt_o),
  .fast_tx_cnt_o   (fast_tx_cnt_o),
  .flags_o         (flags_o),
  .fast_flags_o    (fast_flags_o),
  .err_irq_o       (err_irq_o),
  .fault_state_o   (fault_state_o)
);

// File: tb/tb_canfd_err_track.sv
module tb_canfd_err_track;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] err_evt_i = '0;
  logic       err_tx_i = 1'b0, fast_phase_i = 1'b0, frame_ok_i = 1'b0;
  logic [5:0] flag_clr_i = '0, fast_flag_clr_i = '0;
  logic       err_mask_i = 1'b0;
  logic [7:0] rx_cnt_o, tx_cnt_o, fast_rx_cnt_o, fast_tx_cnt_o;
  logic [5:0] flags_o, fast_flags_o;
  logic       err_irq_o;
  logic [1:0] fault_state_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  canfd_err_track dut (.*);

  // {evt[6], tx, fast, ok, exp rx, exp tx, exp fast rx, exp fast tx}
  localparam logic [40:0] VEC [12] = '{
    {6'b000001, 1'b0, 1'b0, 1'b0, 8'd1, 8'd0,  8'd0, 8'd0},  // R1 rx
    {6'b000100, 1'b1, 1'b0, 1'b0, 8'd1, 8'd8,  8'd0, 8'd0},  // R1 tx
    {6'b000010, 1'b0, 1'b1, 1'b0, 8'd2, 8'd8,  8'd1, 8'd0},  // R3 fast rx
    {6'b010000, 1'b1, 1'b1, 1'b0, 8'd2, 8'd16, 8'd1, 8'd8},  // R3 fast tx
    {6'b000000, 1'b0, 1'b1, 1'b1, 8'd1, 8'd16, 8'd0, 8'd8},  // R2/R3 fast ok
    {6'b000000, 1'b1, 1'b0, 1'b1, 8'd1, 8'd15, 8'd0, 8'd8},  // R2 tx ok
    {6'b001000, 1'b0, 1'b1, 1'b0, 8'd2, 8'd15, 8'd0, 8'd8},  // R3 ack not fast
    {6'b000000, 1'b0, 1'b0, 1'b1, 8'd1, 8'd15, 8'd0, 8'd8},  // R2
    {6'b000000, 1'b0, 1'b0, 1'b1, 8'd0, 8'd15, 8'd0, 8'd8},  // R2
    {6'b000000, 1'b0, 1'b0, 1'b1, 8'd0, 8'd15, 8'd0, 8'd8},  // R2 floor
    {6'b000001, 1'b0, 1'b0, 1'b1, 8'd1, 8'd15, 8'd0, 8'd8},  // R4 err wins
    {6'b100100, 1'b1, 1'b0, 1'b0, 8'd1, 8'd23, 8'd0, 8'd8}   // R1 multi once
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [5:0] evt, input logic tx, input logic fast, input logic ok);
    @(negedge clk_i);
    err_evt_i = evt; err_tx_i = tx; fast_phase_i = fast; frame_ok_i = ok;
    @(negedge clk_i);
    err_evt_i = '0; err_tx_i = 1'b0; fast_phase_i = 1'b0; frame_ok_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11 rx", 32'(rx_cnt_o), 0);
    chk("R11 flags", 32'(flags_o), 0);
    chk("R11 state", 32'(fault_state_o), 0);

    for (int i = 0; i < 12; i++) begin
      step(VEC[i][40:35], VEC[i][34], VEC[i][33], VEC[i][32]);
      chk($sformatf("R1/R2/R4 rx v%0d", i), 32'(rx_cnt_o), 32'(VEC[i][31:24]));
      chk($sformatf("R1/R2/R4 tx v%0d", i), 32'(tx_cnt_o), 32'(VEC[i][23:16]));
      chk($sformatf("R3 fast rx v%0d", i), 32'(fast_rx_cnt_o), 32'(VEC[i][15:8]));
      chk($sformatf("R3 fast tx v%0d", i), 32'(fast_tx_cnt_o), 32'(VEC[i][7:0]));
    end

    chk("R5 flags", 32'(flags_o), 32'h3F);
    chk("R6 fast flags", 32'(fast_flags_o), 32'h12);
    chk("R8 irq masked", 32'(err_irq_o), 0);
    err_mask_i = 1'b1;
    #1 chk("R8 irq on", 32'(err_irq_o), 1);

    @(negedge clk_i); flag_clr_i = 6'h3F;
    @(negedge clk_i); flag_clr_i = '0;
    chk("R7 clear", 32'(flags_o), 0);
    chk("R8 irq fast only", 32'(err_irq_o), 1);
    @(negedge clk_i); fast_flag_clr_i = 6'h3F;
    @(negedge clk_i); fast_flag_clr_i = '0;
    chk("R7 fast clear", 32'(fast_flags_o), 0);
    chk("R8 irq off", 32'(err_irq_o), 0);

    @(negedge clk_i); flag_clr_i = 6'h3F; err_evt_i = 6'b000001;
    @(negedge clk_i); flag_clr_i = '0; err_evt_i = '0;
    chk("R7 set wins", 32'(flags_o), 32'h01);
    chk("R6 no fast set", 32'(fast_flags_o), 0);

    do_reset();
    chk("R11 after reset rx", 32'(rx_cnt_o), 0);
    chk("R11 after reset fast tx", 32'(fast_tx_cnt_o), 0);
    chk("R11 after reset irq", 32'(err_irq_o), 0);

    for (int i = 0; i < 127; i++) step(6'b000001, 1'b0, 1'b1, 1'b0);
    chk("R9 rx 127", 32'(rx_cnt_o), 127);
    chk("R9 active at 127", 32'(fault_state_o), 0);
    step(6'b000001, 1'b0, 1'b0, 1'b0);
    chk("R9 passive at 128", 32'(fault_state_o), 1);
    for (int i = 0; i < 200; i++) step(6'b000001, 1'b0, 1'b0, 1'b0);
    chk("R10 rx saturate", 32'(rx_cnt_o), 255);
    chk("R9 fast not used", 32'(fast_rx_cnt_o), 127);

    do_reset();
    for (int i = 0; i < 16; i++) step(6'b000100, 1'b1, 1'b0, 1'b0);
    chk("R9 tx 128", 32'(tx_cnt_o), 128);
    chk("R9 tx passive", 32'(fault_state_o), 1);
    for (int i = 0; i < 15; i++) step(6'b000100, 1'b1, 1'b0, 1'b0);
    chk("R10 tx 248", 32'(tx_cnt_o), 248);
    chk("R10 not yet off", 32'(fault_state_o), 1);
    step(6'b000100, 1'b1, 1'b0, 1'b0);
    chk("R10 bus-off", 32'(fault_state_o), 2);
    chk("R10 tx saturate", 32'(tx_cnt_o), 255);
    step(6'b000000, 1'b1, 1'b0, 1'b1);
    chk("R10 tx ok dec", 32'(tx_cnt_o), 254);
    chk("R10 bus-off holds", 32'(fault_state_o), 2);
    do_reset();
    chk("R11 bus-off cleared", 32'(fault_state_o), 0);

    finish_run();
  end
endmodule